// File: doc/BRIEF.md
# Tile-Video Scroll Register Write Port

This block sits between a CPU bus and the scroll and address machinery of a tile-based video controller. It watches register-select, write and read strobes and merges each access into three pieces of state: a 15-bit staged address `tmp_addr`, a 3-bit fine horizontal pixel offset `fine_x` and a one-bit first/second write phase `phase`. The scroll port and the address port share that one phase bit. Each of the two writes to either port places bit fields of the data byte into fixed, non-adjacent positions of the staged address.

The block does not hold the live video address. Instead it emits one-cycle requests to the unit that owns it. A load request carries the staged address and tells that unit to copy it. A step request tells it to advance by 1 or by 32. The load request follows the second address-port write. The step request follows any data-port access, and its size follows the increment-mode input sampled with the access.

Top module: `scroll_wport`

## Requirements
- R1: After reset `tmp_addr`, `fine_x` and `phase` are 0, and `load_req` and `step_req` are low.
- R2: A write with select 0 (control) places data bits 1:0 into `tmp_addr` bits 11:10. It leaves every other bit of `tmp_addr`, and also `fine_x` and `phase`, unchanged.
- R3: A read with select 2 (status) clears `phase` to 0 and leaves `tmp_addr` and `fine_x` unchanged.
- R4: A write with select 5 (scroll) while `phase`=0 places data bits 7:3 into `tmp_addr` bits 4:0 and data bits 2:0 into `fine_x`, then sets `phase` to 1.
- R5: A write with select 5 while `phase`=1 places data bits 7:3 into `tmp_addr` bits 9:5 and data bits 2:0 into `tmp_addr` bits 14:12, then clears `phase`.
- R6: A write with select 6 (address) while `phase`=0 places data bits 5:0 into `tmp_addr` bits 13:8, forces bit 14 to 0 and sets `phase` to 1.
- R7: A write with select 6 while `phase`=1 places the data byte into `tmp_addr` bits 7:0 and clears `phase`. In the next cycle, and only that cycle, `load_req` is high and `load_addr` equals the updated `tmp_addr`.
- R8: The scroll port and the address port use the same `phase` bit, so a write to one after a first write to the other takes the second-write behaviour.
- R9: A read or write with select 7 (data) raises `step_req` for exactly the next cycle. With it, `step_incr` is 32 if `inc_by32` was 1 during the access and 1 if it was 0. `step_incr` is 0 whenever `step_req` is low. `tmp_addr`, `fine_x` and `phase` do not change.
- R10: Selects 1, 3 and 4, writes to select 2, and reads of selects 0, 5 and 6 change no state and raise no request.
- R11: When `wr_en` and `rd_en` are both high, only the write is performed.
- R12: `load_req` and `step_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select (0 control, 2 status, 5 scroll, 6 address, 7 data) |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_en | input | 1 | Read strobe, ignored while wr_en is high |
| wdata | input | 8 | Write data byte |
| inc_by32 | input | 1 | Increment mode from the control register: 1 selects a step of 32 |
| tmp_addr | output | 15 | Staged address |
| fine_x | output | 3 | Fine horizontal pixel offset |
| phase | output | 1 | Shared first/second write phase |
| load_req | output | 1 | One-cycle request to load the live address |
| load_addr | output | 15 | Address to load, valid while load_req is high |
| step_req | output | 1 | One-cycle request to advance the live address |
| step_incr | output | 6 | Step size (1 or 32), 0 when step_req is low |

## Verification
The hardest states to reach are those where the shared phase bit is left set by one port and then used by the other. Examples are a first address write followed by a scroll write, or a status read arriving between the two halves of a pair. Purely directed pairs never reach these. The random stimulus therefore concentrates its selects on the scroll, address and status codes, so these cross-port sequences occur often. It also asserts both strobes together at times. A directed replay of a known four-write split-scroll sequence (address, scroll, scroll, address) pins down the final staged address 0x64EF and fine offset 5.

// File: rtl/scroll_wport_pkg.sv
package scroll_wport_pkg;

  localparam int unsigned TA_W   = 15;
  localparam int unsigned FX_W   = 3;
  localparam int unsigned DB_W   = 8;
  localparam int unsigned STEP_W = 6;

  typedef logic [TA_W-1:0] taddr_t;

  typedef struct packed {
    logic ctrl_wr;
    logic stat_rd;
    logic scrl_wr;
    logic addr_wr;
    logic data_acc;
  } wp_evt_t;

  // control write: nametable select bits into 11:10
  function automatic taddr_t mix_ctrl(input taddr_t t, input logic [1:0] nt);
    taddr_t r;
    r = t;
    r[11:10] = nt;
    return r;
  endfunction

  // scroll write, first or second half
  function automatic taddr_t mix_scroll(input taddr_t t, input logic [DB_W-1:0] d,
                                        input logic second);
    taddr_t r;
    r = t;
    if (second) begin
      r[9:5]   = d[7:3];
      r[14:12] = d[2:0];
    end else begin
      r[4:0]   = d[7:3];
    end
    return r;
  endfunction

  // address write, first or second half
  function automatic taddr_t mix_addr(input taddr_t t, input logic [DB_W-1:0] d,
                                      input logic second);
    taddr_t r;
    r = t;
    if (second) begin
      r[7:0] = d;
    end else begin
      r[13:8] = d[5:0];
      r[14]   = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [STEP_W-1:0] step_amount(input logic wide);
    return wide ? STEP_W'(32) : STEP_W'(1);
  endfunction

endpackage

// File: rtl/scroll_wport_decode.sv
module scroll_wport_decode
  import scroll_wport_pkg::*;
#(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned SEL_CTRL  = 0,
  parameter int unsigned SEL_STAT  = 2,
  parameter int unsigned SEL_SCRL  = 5,
  parameter int unsigned SEL_ADDR  = 6,
  parameter int unsigned SEL_DATA  = 7
) (
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  output wp_evt_t          evt
);

  logic hit_ctrl, hit_stat, hit_scrl, hit_addr, hit_data;
  logic rd_only;

  assign hit_ctrl = (reg_sel == SEL_W'(SEL_CTRL));
  assign hit_stat = (reg_sel == SEL_W'(SEL_STAT));
  assign hit_scrl = (reg_sel == SEL_W'(SEL_SCRL));
  assign hit_addr = (reg_sel == SEL_W'(SEL_ADDR));
  assign hit_data = (reg_sel == SEL_W'(SEL_DATA));

  // a write masks a read in the same cycle
  assign rd_only = rd_en & ~wr_en;

  always_comb begin
    evt          = '0;
    evt.ctrl_wr  = wr_en & hit_ctrl;
    evt.stat_rd  = rd_only & hit_stat;
    evt.scrl_wr  = wr_en & hit_scrl;
    evt.addr_wr  = wr_en & hit_addr;
    evt.data_acc = (wr_en | rd_only) & hit_data;
  end

  // at most one event per access (R11)
  always_comb begin
    a_one_evt_r11: assert ($countones(evt) <= 1)
      else $error("more than one decoded event");
  end

endmodule

// File: rtl/scroll_wport_state.sv
module scroll_wport_state
  import scroll_wport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wp_evt_t           evt,
  input  logic [DB_W-1:0]   wdata,
  output taddr_t            t_q,
  output logic [FX_W-1:0]   x_q,
  output logic              w_q,
  output logic              load_evt
);

  taddr_t          t_nx;
  logic [FX_W-1:0] x_nx;
  logic            w_nx;

  assign load_evt = evt.addr_wr & w_q;

  always_comb begin
    t_nx = t_q;
    x_nx = x_q;
    w_nx = w_q;
    if (evt.ctrl_wr) begin
      t_nx = mix_ctrl(t_q, wdata[1:0]);
    end
    if (evt.stat_rd) begin
      w_nx = 1'b0;
    end
    if (evt.scrl_wr) begin
      t_nx = mix_scroll(t_q, wdata, w_q);
      if (!w_q) x_nx = wdata[FX_W-1:0];
      w_nx = ~w_q;
    end
    if (evt.addr_wr) begin
      t_nx = mix_addr(t_q, wdata, w_q);
      w_nx = ~w_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_q <= '0;
      x_q <= '0;
      w_q <= 1'b0;
    end else begin
      t_q <= t_nx;
      x_q <= x_nx;
      w_q <= w_nx;
    end
  end

  p_ctrl_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.ctrl_wr |=> (t_q[9:0] == $past(t_q[9:0])) && (t_q[14:12] == $past(t_q[14:12]))
                    && (t_q[11:10] == $past(wdata[1:0])) && (w_q == $past(w_q)));

  p_status_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stat_rd |=> !w_q && (t_q == $past(t_q)) && (x_q == $past(x_q)));

  p_addr_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.addr_wr && !w_q) |=> !t_q[14] && w_q && (t_q[13:8] == $past(wdata[5:0])));

  p_shared_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.scrl_wr || evt.addr_wr) |=> (w_q != $past(w_q)));

  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt.data_acc |=> (t_q == $past(t_q)) && (x_q == $past(x_q)) && (w_q == $past(w_q)));

endmodule

// File: rtl/scroll_wport_req.sv
module scroll_wport_req
  import scroll_wport_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_evt,
  input  logic               data_acc,
  input  logic               inc_by32,
  input  logic [DB_W-1:0]    wdata,
  input  taddr_t             t_q,
  output logic               load_req,
  output taddr_t             load_addr,
  output logic               step_req,
  output logic [STEP_W-1:0]  step_incr
);

  logic wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_req <= 1'b0;
      step_req <= 1'b0;
      wide_q   <= 1'b0;
    end else begin
      load_req <= load_evt;
      step_req <= data_acc;
      wide_q   <= data_acc & inc_by32;
    end
  end

  // the staged register already holds the merged value when the pulse is out
  assign load_addr = t_q;
  assign step_incr = step_req ? step_amount(wide_q) : '0;

  p_load_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !load_req);

  p_load_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> (load_addr[7:0] == $past(wdata)));

  p_step_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> step_req && (step_incr == ($past(inc_by32) ? 6'd32 : 6'd1)));

  p_step_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !step_req |-> (step_incr == '0));

  p_req_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_req && step_req));

endmodule

// File: rtl/scroll_wport.sv
module scroll_wport
  import scroll_wport_pkg::*;
#(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned SEL_CTRL = 0,
  parameter int unsigned SEL_STAT = 2,
  parameter int unsigned SEL_SCRL = 5,
  parameter int unsigned SEL_ADDR = 6,
  parameter int unsigned SEL_DATA = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  input  logic              inc_by32,
  output logic [14:0]       tmp_addr,
  output logic [2:0]        fine_x,
  output logic              phase,
  output logic              load_req,
  output logic [14:0]       load_addr,
  output logic              step_req,
  output logic [5:0]        step_incr
);

  wp_evt_t evt;
  taddr_t  t_q;
  logic    load_evt;

  scroll_wport_decode #(
    .SEL_W(SEL_W), .SEL_CTRL(SEL_CTRL), .SEL_STAT(SEL_STAT),
    .SEL_SCRL(SEL_SCRL), .SEL_ADDR(SEL_ADDR), .SEL_DATA(SEL_DATA)
  ) u_dec (
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .evt     (evt)
  );

  scroll_wport_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .wdata    (wdata),
    .t_q      (t_q),
    .x_q      (fine_x),
    .w_q      (phase),
    .load_evt (load_evt)
  );

  scroll_wport_req u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .data_acc  (evt.data_acc),
    .inc_by32  (inc_by32),
    .wdata     (wdata),
    .t_q       (t_q),
    .load_req  (load_req),
    .load_addr (load_addr),
    .step_req  (step_req),
    .step_incr (step_incr)
  );

  assign tmp_addr = t_q;

endmodule

// File: tb/tb_scroll_wport.sv
`timescale 1ns/1ps
module tb_scroll_wport;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, inc_by32 = 1'b0;
  logic [7:0]  wdata = '0;
  logic [14:0] tmp_addr, load_addr;
  logic [2:0]  fine_x;
  logic        phase, load_req, step_req;
  logic [5:0]  step_incr;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // model state
  logic [14:0] mt;
  logic [2:0]  mx;
  logic        mw;

  always #2 clk = ~clk;

  scroll_wport dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .inc_by32(inc_by32), .tmp_addr(tmp_addr), .fine_x(fine_x),
    .phase(phase), .load_req(load_req), .load_addr(load_addr),
    .step_req(step_req), .step_incr(step_incr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // bench's own statement of the field placement rules
  function automatic logic [14:0] put(input logic [14:0] v, input int lo, input int n,
                                     input logic [7:0] f);
    logic [14:0] r = v;
    for (int i = 0; i < n; i++) r[lo+i] = f[i];
    return r;
  endfunction

  task automatic op(input logic [2:0] s, input logic w, input logic r,
                    input logic [7:0] d, input logic inc);
    logic [14:0] et; logic [2:0] ex; logic ew, eload, estep;
    string tag;
    et = mt; ex = mx; ew = mw; eload = 0; estep = 0; tag = "R10";
    if (w) begin
      if (r) tag = "R11";
      case (s)
        3'd0: begin et = put(mt, 10, 2, d); if (!r) tag = "R2"; end
        3'd5: begin
          if (!mw) begin et = put(mt, 0, 5, d >> 3); ex = d[2:0]; if (!r) tag = "R4"; end
          else begin et = put(put(mt, 5, 5, d >> 3), 12, 3, d); if (!r) tag = "R5"; end
          ew = ~mw;
        end
        3'd6: begin
          if (!mw) begin et = put(put(mt, 8, 6, d), 14, 1, 8'h0); if (!r) tag = "R6"; end
          else begin et = put(mt, 0, 8, d); eload = 1; if (!r) tag = "R7"; end
          ew = ~mw;
        end
        3'd7: begin estep = 1; if (!r) tag = "R9"; end
        default: ;
      endcase
    end else if (r) begin
      if (s == 3'd2) begin ew = 0; tag = "R3"; end
      else if (s == 3'd7) begin estep = 1; tag = "R9"; end
    end
    @(negedge clk);
    reg_sel = s; wr_en = w; rd_en = r; wdata = d; inc_by32 = inc;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    mt = et; mx = ex; mw = ew;
    chk(tag, tmp_addr, et, "tmp_addr");
    chk(tag, fine_x, ex, "fine_x");
    chk(tag, phase, ew, "phase");
    chk(eload ? "R7" : tag, load_req, eload, "load_req");
    if (eload) chk("R7", load_addr, et, "load_addr");
    chk(estep ? "R9" : tag, step_req, estep, "step_req");
    chk("R9", step_incr, estep ? (inc ? 32 : 1) : 0, "step_incr");
    chk("R12", load_req & step_req, 0, "both requests");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mt = '0; mx = '0; mw = 0;
    void'($urandom(32'h5C0_11A));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", tmp_addr, 0, "tmp_addr");
    chk("R1", fine_x, 0, "fine_x");
    chk("R1", phase, 0, "phase");
    chk("R1", load_req, 0, "load_req");
    chk("R1", step_req, 0, "step_req");
    rst_n = 1;
    // directed split-scroll replay, R8 cross-port phase
    op(3'd6, 1, 0, 8'h04, 0);
    op(3'd5, 1, 0, 8'h3E, 0);
    op(3'd5, 1, 0, 8'h7D, 0);
    op(3'd6, 1, 0, 8'hEF, 0);
    chk("R8", tmp_addr, 15'h64EF, "replay tmp_addr");
    chk("R8", fine_x, 3'd5, "replay fine_x");
    // status read between halves (R3), then data accesses (R9)
    op(3'd5, 1, 0, 8'hFF, 0);
    op(3'd2, 0, 1, 8'h00, 0);
    op(3'd5, 1, 0, 8'h13, 0);
    op(3'd7, 1, 0, 8'h55, 1);
    op(3'd7, 0, 1, 8'h00, 0);
    op(3'd0, 1, 0, 8'hFF, 0);
    op(3'd2, 1, 1, 8'h00, 0);   // R11: write wins, read ignored
    op(3'd6, 0, 1, 8'h3F, 0);   // R10: read of address port
    op(3'd3, 1, 0, 8'hA5, 1);   // R10
    // random stimulus weighted toward the toggled ports
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] s; logic w, r; int pick;
      pick = $urandom % 10;
      case (pick)
        0, 1, 2: s = 3'd5;
        3, 4, 5: s = 3'd6;
        6:       s = 3'd2;
        7:       s = 3'd7;
        8:       s = 3'd0;
        default: s = 3'($urandom);
      endcase
      w = ($urandom % 4) != 0;
      r = ($urandom % 3) == 0;
      op(s, w, r, 8'($urandom), 1'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule